// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read side of a serial configuration store that feeds an FPGA loading itself in master serial mode. A constant bit array, set by a parameter, leaves the block one bit per configuration clock. A single bit-address counter walks the array. A chip-enable input gates the counter and the output. A shared reset/output-enable pin, whose polarity is set by a strap input, either clears the counter or enables the output. When the last bit has been shifted out, a chip-enable output passes control to the next device in a chain.

A power-on sequence of a parameterised length holds the counter cleared and pulls the ready line low. No data is driven until that sequence ends. The tri-state data pin is modelled as a value plus a drive enable. The open-drain ready pin is modelled as a pull-down request. Devices in a chain share the data line: each `ceo_n` feeds the next `ce_n`.

Top module: `cfg_serial_rom`

## Requirements
- R1: While the reset level is present on `roe`, `dout_oe` is 0 in the same cycle whatever `ce_n` is. Every rising edge seen in that state clears the bit counter and the end-of-array flag, so the next enabled read starts at bit 0.
- R2: When `ce_n`=0, the output enable is active and the power-on sequence is over, the block drives `dout_oe`=1 and `dout` = stream bit k, where k is the counter. Each rising edge then advances k by one. Bit k is `CONTENT[k ^ 7]`: byte b sits in `CONTENT[8b+7:8b]` and is sent most significant bit first.
- R3: While `ce_n`=1 and no reset is present, the counter and the end flag hold their values, `dout_oe`=0 and `standby`=1.
- R4: On the rising edge that consumes the last bit (k = 8*BYTES-1), `ceo_n` goes low and `dout_oe` goes low in the same cycle. No data is driven again until a reset.
- R5: Once the array has ended, `ceo_n` equals `ce_n` for as long as no reset is present. A reset forces `ceo_n` to 1, and it stays 1 until the whole array has been read again.
- R6: With `pol_inv`=0, `roe`=0 is the reset and `roe`=1 enables the output. With `pol_inv`=1 the two levels swap.
- R7: While `por_n`=0 the counter is cleared and `ready_pd`=1. After `por_n` rises, `ready_pd` stays 1 for exactly POR_CYCLES rising edges and then drops to 0. `dout_oe` is 0 while `ready_pd`=1.
- R8: Two devices chained through `ceo_n`→`ce_n` produce one gap-free stream: the second device's bit 0 appears in the cycle right after the first device's last bit, and the two never drive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; rising edges advance the counter |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| roe | input | 1 | Shared reset / output-enable pin |
| pol_inv | input | 1 | Polarity strap for `roe` (0: reset low, enable high) |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Drive enable for `dout` (0 = high impedance) |
| ceo_n | output | 1 | Chip-enable output to the next device, active low |
| standby | output | 1 | High while chip enable is inactive |
| ready_pd | output | 1 | Open-drain ready: 1 means the line is pulled low |

## Verification
The bench chains two instances and checks that the stream stays gap-free across the handoff and that the line never has two drivers. A counter that overshoots or stops one bit early would show up as a stray extra bit or a one-cycle hole. The chip-enable output is exercised after the end of the array: it must follow `ce_n`, and it must stay high once a reset has occurred. A design that releases the latch early would hand the line back mid-way. Bit positions are chosen so that a counter that does not freeze in standby, that ignores a reset given while chip enable is high, or that misreads the inverted polarity would present a wrong bit. The length of the power-on window is checked to the exact edge.

// File: rtl/cfg_serial_rom.sv
module cfg_serial_rom #(
  parameter int BYTES = 16,
  parameter int POR_CYCLES = 8,
  parameter logic [BYTES*8-1:0] CONTENT = {BYTES{8'hA5}}
) (
  input  logic clk,
  input  logic por_n,
  input  logic ce_n,
  input  logic roe,
  input  logic pol_inv,
  output logic dout,
  output logic dout_oe,
  output logic ceo_n,
  output logic standby,
  output logic ready_pd
);
  localparam int NBITS = BYTES * 8;
  localparam int AW = $clog2(NBITS);
  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam logic [AW-1:0] LAST = AW'(NBITS - 1);
  localparam logic [PW-1:0] POR_END = PW'(POR_CYCLES);

  logic [AW-1:0] addr;
  logic [PW-1:0] por_q;
  logic ended;
  logic busy, rst_act, go;
  logic [AW-1:0] rd_idx;

  assign busy    = (por_q != POR_END);
  assign rst_act = pol_inv ? roe : ~roe;
  assign go      = ~busy & ~ce_n & ~rst_act & ~ended;
  assign rd_idx  = addr ^ AW'(7);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_q <= '0;
    else if (busy) por_q <= por_q + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr  <= '0;
      ended <= 1'b0;
    end else if (busy || rst_act) begin
      addr  <= '0;
      ended <= 1'b0;
    end else if (go) begin
      if (addr == LAST) begin
        addr  <= '0;
        ended <= 1'b1;
      end else begin
        addr <= addr + 1'b1;
      end
    end
  end

  assign dout_oe  = go;
  assign dout     = go & CONTENT[rd_idx];
  assign ceo_n    = (ended && !rst_act) ? ce_n : 1'b1;
  assign standby  = ce_n;
  assign ready_pd = busy;
endmodule

// File: rtl/cfg_serial_rom_chk.sv
module cfg_serial_rom_chk #(
  parameter int AW = 7,
  parameter int NBITS = 128
) (
  input logic clk,
  input logic por_n,
  input logic ce_n,
  input logic roe,
  input logic pol_inv,
  input logic dout_oe,
  input logic ceo_n,
  input logic ready_pd,
  input logic [AW-1:0] addr,
  input logic ended
);
  localparam logic [AW-1:0] LAST = AW'(NBITS - 1);
  logic rst_lvl;
  assign rst_lvl = pol_inv ? roe : !roe;

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (!por_n)
    rst_lvl |=> (addr == '0 && !ended));
  p_reset_hiz_r1: assert property (@(posedge clk) disable iff (!por_n)
    rst_lvl |-> !dout_oe);
  p_advance_r2: assert property (@(posedge clk) disable iff (!por_n)
    (dout_oe && addr != LAST) |=> (addr == AW'($past(addr) + 1'b1)));
  p_freeze_r3: assert property (@(posedge clk) disable iff (!por_n)
    (ce_n && !rst_lvl && !ready_pd) |=> ($stable(addr) && $stable(ended)));
  p_handoff_r4: assert property (@(posedge clk) disable iff (!por_n)
    (dout_oe && addr == LAST) |=> ended);
  p_ended_quiet_r4: assert property (@(posedge clk) disable iff (!por_n)
    ended |-> !dout_oe);
  p_ceo_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
    (ended && !rst_lvl && !ce_n) |-> !ceo_n);
  p_ceo_idle_r5: assert property (@(posedge clk) disable iff (!por_n)
    !ended |-> ceo_n);
  p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!por_n)
    ready_pd |-> !dout_oe);
endmodule

bind cfg_serial_rom cfg_serial_rom_chk #(.AW(AW), .NBITS(NBITS)) u_chk (
  .clk(clk), .por_n(por_n), .ce_n(ce_n), .roe(roe), .pol_inv(pol_inv),
  .dout_oe(dout_oe), .ceo_n(ceo_n), .ready_pd(ready_pd),
  .addr(addr), .ended(ended)
);

// File: tb/sim_cfg_serial_rom.sv
module sim_cfg_serial_rom;
  localparam int CLK_PERIOD = 10;
  localparam int POR = 5;
  localparam int B0 = 4;
  localparam int B1 = 2;
  localparam int N0 = B0 * 8;
  localparam int N1 = B1 * 8;
  localparam logic [N0-1:0] C0 = 32'h3CA5698B;
  localparam logic [N1-1:0] C1 = 16'h5AC1;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ce_n = 1'b0;
  logic roe = 1'b1;
  logic pol = 1'b0;
  logic d0, oe0, ceo0, sb0, rdy0;
  logic d1, oe1, ceo1, sb1, rdy1;
  int checks = 0;
  int errs = 0;
  int overlap = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_rom #(.BYTES(B0), .POR_CYCLES(POR), .CONTENT(C0)) u0 (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .roe(roe), .pol_inv(pol),
    .dout(d0), .dout_oe(oe0), .ceo_n(ceo0), .standby(sb0), .ready_pd(rdy0));

  cfg_serial_rom #(.BYTES(B1), .POR_CYCLES(POR), .CONTENT(C1)) u1 (
    .clk(clk), .por_n(por_n), .ce_n(ceo0), .roe(roe), .pol_inv(pol),
    .dout(d1), .dout_oe(oe1), .ceo_n(ceo1), .standby(sb1), .ready_pd(rdy1));

  always @(negedge clk) if (oe0 && oe1) overlap++;

  function automatic logic e0(int k); return C0[k ^ 7]; endfunction
  function automatic logic e1(int k); return C1[k ^ 7]; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_power_on;
    step(2);
    chk(rdy0 == 1, "R7 ready pulled during por", rdy0, 1);
    chk(oe0 == 0 && oe1 == 0, "R7 no drive during por", oe0 | oe1, 0);
    chk(ceo0 == 1, "R5 ceo high at reset", ceo0, 1);
    por_n = 1'b1;
    step(POR - 1);
    chk(rdy0 == 1 && oe0 == 0, "R7 window not yet over", rdy0, 1);
    step();
    chk(rdy0 == 0 && rdy1 == 0, "R7 ready released", rdy0 | rdy1, 0);
    chk(oe0 == 1 && d0 == e0(0), "R2 first bit after por", d0, e0(0));
  endtask

  task automatic t_chain_stream;
    int bad = 0;
    for (int k = 0; k < N0; k++) begin
      if (!(oe0 && !oe1 && d0 == e0(k) && ceo0)) begin
        bad++;
        $display("FAIL R2 bit %0d actual=%0d expected=%0d", k, d0, e0(k));
      end
      step();
    end
    chk(bad == 0, "R2 first device stream", bad, 0);
    chk(ceo0 == 0 && oe0 == 0, "R4 handoff at last bit", ceo0 | oe0, 0);
    chk(oe1 == 1 && d1 == e1(0), "R8 next device bit 0 without gap", d1, e1(0));
    bad = 0;
    for (int k = 0; k < N1; k++) begin
      if (!(oe1 && !oe0 && d1 == e1(k))) begin
        bad++;
        $display("FAIL R8 bit %0d actual=%0d expected=%0d", k, d1, e1(k));
      end
      step();
    end
    chk(bad == 0, "R8 second device stream", bad, 0);
    chk(oe1 == 0 && ceo1 == 0, "R4 second device ends", oe1 | ceo1, 0);
  endtask

  task automatic t_ceo_follow;
    ce_n = 1'b1; #1;
    chk(ceo0 == 1 && sb0 == 1 && sb1 == 1, "R5 ceo follows ce high", ceo0, 1);
    ce_n = 1'b0; #1;
    chk(ceo0 == 0 && oe0 == 0, "R5 ceo low again, no redrive", ceo0 | oe0, 0);
    step(2);
    chk(ceo0 == 0 && oe0 == 0, "R5 ceo latched while enabled", ceo0 | oe0, 0);
    roe = 1'b0; #1;
    chk(ceo0 == 1 && oe0 == 0, "R1 reset releases ceo and data", ceo0 | oe0, 1);
    step();
    roe = 1'b1; #1;
    chk(ceo0 == 1, "R5 ceo stays high after reset", ceo0, 1);
    chk(oe0 == 1 && d0 == e0(0), "R1 restart at bit 0", d0, e0(0));
  endtask

  task automatic t_standby;
    step(3);
    chk(d0 == e0(3), "R2 bit 3 before standby", d0, e0(3));
    ce_n = 1'b1; #1;
    chk(oe0 == 0 && sb0 == 1, "R3 standby hiZ", oe0, 0);
    step(3);
    ce_n = 1'b0; #1;
    chk(oe0 == 1 && d0 == e0(3), "R3 counter frozen", d0, e0(3));
    step();
    chk(d0 == e0(4), "R3 resumes next bit", d0, e0(4));
  endtask

  task automatic t_reset_ce_high;
    step();
    ce_n = 1'b1; roe = 1'b0;
    step();
    roe = 1'b1;
    step();
    ce_n = 1'b0; #1;
    chk(oe0 == 1 && d0 == e0(0), "R1 reset with ce high clears", d0, e0(0));
  endtask

  task automatic t_polarity;
    step(2);
    chk(d0 == e0(2), "R6 bit 2 normal polarity", d0, e0(2));
    pol = 1'b1; #1;
    chk(oe0 == 0, "R6 roe high is reset when inverted", oe0, 0);
    step();
    roe = 1'b0; #1;
    chk(oe0 == 1 && d0 == e0(0), "R6 roe low enables when inverted", d0, e0(0));
    step();
    chk(d0 == e0(1), "R6 advance under inverted polarity", d0, e0(1));
    pol = 1'b0; #1;
    chk(oe0 == 0, "R6 roe low is reset in normal polarity", oe0, 0);
    step();
    roe = 1'b1; #1;
    chk(oe0 == 1 && d0 == e0(0), "R6 normal polarity restart", d0, e0(0));
  endtask

  initial begin
    t_power_on();
    t_chain_stream();
    t_ceo_follow();
    t_standby();
    t_reset_ce_high();
    t_polarity();
    chk(overlap == 0, "R8 single driver on line", overlap, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule